// File: doc/BRIEF.md
# Dual-Edge Decade Ring Counter

This block counts pulses modulo ten and presents the count as ten one-hot lines plus an active-low carry. The count is held in a five-bit twisted-ring (Johnson) register. Two asynchronous count inputs drive it. One advances the count on its rising edge while the other is low. The other advances the count on its falling edge while the first is high. Each input therefore acts as an enable for the other. An active-high clear input forces the count to zero.

All three external controls are brought into the system clock domain through a two-stage synchroniser. A third sample of each count input is kept for edge detection. A qualifying edge yields one advance pulse. A result is visible at the outputs on the third rising system-clock edge after the input changes. The system reset is synchronous and active low. Unused ring codes are corrected to count zero on the next advance.

Top module: `decade_ring_counter`

## Requirements
- R1: After the system reset (rst_n low on a rising clock edge), dec_o equals 10'b0000000001 (count 0) and carry_n_o is 1.
- R2: A rising edge on up_i while dn_i is low advances the count by one.
- R3: A falling edge on dn_i while up_i is high advances the count by one.
- R4: A rising edge on up_i while dn_i is high does not change the count. A falling edge on dn_i while up_i is low does not change the count.
- R5: A falling edge on up_i or a rising edge on dn_i does not change the count. When up_i rises and dn_i falls together, the count advances exactly once.
- R6: Bit k of dec_o is the only high bit when the count is k. The count runs 0,1,…,9 and then wraps to 0.
- R7: carry_n_o is 1 for counts 0 through 4 and 0 for counts 5 through 9.
- R8: While the synchronised clr_i is high, dec_o is 10'b0000000001 and carry_n_o is 1, whatever the count inputs do. Clear wins over an advance in the same cycle. After release, the next qualifying edge gives count 1.
- R9: A change on up_i, dn_i or clr_i driven just after a rising clock edge is not yet visible after two rising edges. It is visible after the third rising edge.
- R10: From any of the 22 ring codes outside the ten-state sequence, the next advance gives count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| up_i | input | 1 | Count input, advances on rising edge while dn_i is low |
| dn_i | input | 1 | Count input, advances on falling edge while up_i is high |
| clr_i | input | 1 | Active-high clear to count 0 |
| dec_o | output | 10 | One-hot decoded count, bit k high for count k |
| carry_n_o | output | 1 | Active-low carry, low for counts 5 to 9 |

## Verification
Every input change reaches the outputs on the third rising clock edge after it is driven: two synchroniser stages, then the ring register update. The bench drives inputs on falling edges and waits four falling edges before it samples. That leaves a full cycle of margin after the third rising edge. The latency test samples once after two rising edges to check that nothing has changed yet, and once after three to check that the new count is there. Illegal ring codes are forced into the state register while no advance is pending, and the result is checked one advance later.

// File: rtl/drc_pkg.sv
// Shared widths and ring helpers for the decade ring counter.
// Assumes a Johnson ring whose legal codes have at most one bit boundary.
package drc_pkg;
    localparam int RING_W  = 5;
    localparam int COUNT_N = 2 * RING_W;

    typedef logic [RING_W-1:0] ring_t;

    // True when the code belongs to the 2*RING_W-state twisted-ring sequence.
    function automatic logic ring_ok(input ring_t s);
        int flips;
        flips = 0;
        for (int i = 0; i < RING_W - 1; i++) begin
            if (s[i] != s[i+1]) flips++;
        end
        return (flips <= 1);
    endfunction

    // Next ring code; any illegal code is sent straight to the zero code.
    function automatic ring_t ring_step(input ring_t s);
        if (ring_ok(s)) return {s[RING_W-2:0], ~s[RING_W-1]};
        return '0;
    endfunction
endpackage

// File: rtl/drc_sync.sv
// Multi-stage synchroniser for a bus of independent asynchronous bits.
// Assumes each bit is a level that changes far slower than clk.
module drc_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    // First stage samples the raw inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        // Each further stage re-samples the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= '0;
            else        chain[g] <= chain[g-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/drc_edge_qual.sv
// Turns the synchronised count inputs into one advance pulse per qualifying edge:
// a rising edge of up_s while dn_s is low, or a falling edge of dn_s while up_s is high.
// Assumes both inputs are already synchronous to clk.
module drc_edge_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic up_s,
    input  logic dn_s,
    output logic adv
);
    logic up_q, dn_q;

    // Hold the previous synchronised samples for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else begin
            up_q <= up_s;
            dn_q <= dn_s;
        end
    end

    // Each input gates the other; coincident qualifying edges merge into one pulse.
    assign adv = (up_s & ~up_q & ~dn_s) | (dn_q & ~dn_s & up_s);

    // R5: an advance only ever follows a change on one of the inputs.
    p_adv_needs_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> ((up_s != up_q) || (dn_s != dn_q)));
endmodule

// File: rtl/drc_johnson_ring.sv
// Five-stage twisted-ring state register with clear and self-correction.
// Assumes adv is a single-cycle pulse and clr is synchronous to clk.
module drc_johnson_ring
    import drc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  adv,
    input  logic  clr,
    output ring_t state_q
);
    // Clear outranks an advance; the state holds when neither is present.
    always_ff @(posedge clk) begin
        if (!rst_n)    state_q <= '0;
        else if (clr)  state_q <= '0;
        else if (adv)  state_q <= ring_step(state_q);
    end

    // R8: a clear leaves the ring at the zero code.
    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (state_q == '0));

    // R10: every advance lands on a legal code.
    p_legal_after_adv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> ring_ok(state_q));
endmodule

// File: rtl/drc_decode.sv
// Decodes a twisted-ring code into one-hot count lines using adjacent bit pairs.
// Assumes a legal code; illegal codes may light several or no lines.
module drc_decode
    import drc_pkg::*;
(
    input  ring_t               state,
    output logic [COUNT_N-1:0]  dec
);
    // The two all-equal codes are the wrap points of the ring.
    assign dec[0]      = ~state[RING_W-1] & ~state[0];
    assign dec[RING_W] =  state[RING_W-1] &  state[0];

    for (genvar k = 1; k < RING_W; k++) begin : g_pair
        // Filling phase: the boundary between a one and the zeros above it.
        assign dec[k]        =  state[k-1] & ~state[k];
        // Emptying phase: the boundary between the zeros and the ones above them.
        assign dec[RING_W+k] = ~state[k-1] &  state[k];
    end
endmodule

// File: rtl/decade_ring_counter.sv
// Decade counter with two opposite-polarity count inputs and an active-high clear.
// Assumes up_i, dn_i and clr_i are asynchronous levels; the result is visible
// three clk rising edges after an input change.
module decade_ring_counter
    import drc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               up_i,
    input  logic               dn_i,
    input  logic               clr_i,
    output logic [COUNT_N-1:0] dec_o,
    output logic               carry_n_o
);
    logic [2:0] raw, synced;
    logic       adv;
    ring_t      state;

    assign raw = {clr_i, dn_i, up_i};

    drc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
    );

    drc_edge_qual u_edge (
        .clk(clk), .rst_n(rst_n), .up_s(synced[0]), .dn_s(synced[1]), .adv(adv)
    );

    drc_johnson_ring u_ring (
        .clk(clk), .rst_n(rst_n), .adv(adv), .clr(synced[2]), .state_q(state)
    );

    drc_decode u_dec (
        .state(state), .dec(dec_o)
    );

    // Carry is high through the filling half of the ring.
    assign carry_n_o = ~state[RING_W-1];

    // R6: a legal ring code lights exactly one decoded line.
    p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ring_ok(state) |-> ($countones(dec_o) == 1));

    // R7: carry is low exactly when an upper-half line is lit.
    p_carry_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ring_ok(state) |-> (carry_n_o == (dec_o[COUNT_N-1:RING_W] == '0)));
endmodule

// File: tb/decade_ring_counter_tb.sv
module decade_ring_counter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       up_i = 1'b0;
    logic       dn_i = 1'b0;
    logic       clr_i = 1'b0;
    logic [9:0] dec_o;
    logic       carry_n_o;
    int         checks = 0;
    int         fails = 0;
    logic [4:0] frc;
    logic [4:0] seq [10];
    logic       is_seq;

    always #10 clk = ~clk;

    decade_ring_counter u_dut (
        .clk(clk), .rst_n(rst_n), .up_i(up_i), .dn_i(dn_i), .clr_i(clr_i),
        .dec_o(dec_o), .carry_n_o(carry_n_o)
    );

    // {up, dn, expected count after the step}
    localparam logic [5:0] VEC [26] = '{
        {2'b10, 4'd1}, {2'b00, 4'd1}, {2'b10, 4'd2}, {2'b11, 4'd2},
        {2'b10, 4'd3}, {2'b00, 4'd3}, {2'b01, 4'd3}, {2'b11, 4'd3},
        {2'b01, 4'd3}, {2'b00, 4'd3}, {2'b10, 4'd4}, {2'b00, 4'd4},
        {2'b10, 4'd5}, {2'b00, 4'd5}, {2'b10, 4'd6}, {2'b11, 4'd6},
        {2'b10, 4'd7}, {2'b00, 4'd7}, {2'b10, 4'd8}, {2'b11, 4'd8},
        {2'b10, 4'd9}, {2'b00, 4'd9}, {2'b10, 4'd0}, {2'b01, 4'd0},
        {2'b10, 4'd1}, {2'b00, 4'd1}
    };

    task automatic check(input string req, input int exp);
        logic [10:0] want;
        want = {10'b1 << exp, (exp < 5) ? 1'b1 : 1'b0};
        checks++;
        if ({dec_o, carry_n_o} !== want) begin
            fails++;
            $display("FAIL %s: got dec=%b carry_n=%b exp dec=%b carry_n=%b",
                     req, dec_o, carry_n_o, want[10:1], want[0]);
        end
    endtask

    task automatic step(input logic up, input logic dn);
        up_i = up;
        dn_i = dn;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        seq[0] = 5'b0;
        for (int k = 1; k < 10; k++) seq[k] = {seq[k-1][3:0], ~seq[k-1][4]};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state", 0);

        // R2 R3 R4 R5 R6 R7: table walk through all counts, gating and wrap
        for (int i = 0; i < 26; i++) begin
            step(VEC[i][5], VEC[i][4]);
            check($sformatf("R2/R3/R4/R5/R6/R7 vector %0d", i), int'(VEC[i][3:0]));
        end

        // R9: latency of three rising edges
        up_i = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 not yet visible", 1);
        @(negedge clk);
        check("R9 visible after third edge", 2);
        step(1'b0, 1'b0);

        // R8: clear holds count 0 despite count activity
        clr_i = 1'b1;
        repeat (4) @(negedge clk);
        check("R8 clear asserted", 0);
        step(1'b1, 1'b0);
        check("R8 ignore up edge in clear", 0);
        step(1'b0, 1'b0);
        clr_i = 1'b0;
        repeat (4) @(negedge clk);
        check("R8 after release", 0);
        step(1'b1, 1'b0);
        check("R8 first edge after release", 1);
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        check("R2 count 2 before priority test", 2);
        step(1'b0, 1'b0);
        // R8: clear and advance arrive together; clear wins
        clr_i = 1'b1;
        step(1'b1, 1'b0);
        check("R8 clear priority", 0);
        clr_i = 1'b0;
        step(1'b0, 1'b0);

        // R1: mid-run system reset
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset", 0);

        // R10: each unused code recovers to count 0 on the next advance
        for (int c = 0; c < 32; c++) begin
            is_seq = 1'b0;
            for (int k = 0; k < 10; k++) if (seq[k] == 5'(c)) is_seq = 1'b1;
            if (!is_seq) begin
                frc = 5'(c);
                force u_dut.u_ring.state_q = frc;
                @(negedge clk);
                release u_dut.u_ring.state_q;
                step(1'b1, 1'b0);
                check($sformatf("R10 recover from %b", frc), 0);
                step(1'b0, 1'b0);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule